// File: doc/BRIEF.md
# Register-Access Two-Wire Target with Strapped Device Address

This block is an I2C-compatible target that lets an external host read and write a bank of 32-bit registers over the two-wire bus. SCL and SDA arrive as plain inputs. SDA is driven through a separate open-drain enable: when `sda_oe` is high the pad pulls the line low, and otherwise the line is released. Both lines pass through two-flop synchronizers. Start and Stop are recognised from SDA edges that occur while SCL is high. The target never stretches the clock.

Two strap inputs are captured once, on the first clock after reset is released. They choose one of four consecutive 7-bit device addresses. The register pointer is 16 bits wide and the host sends it low byte first. Data words travel least-significant byte first. The pointer is word aligned and advances by one word after every word that is committed or fetched. A Stop or a repeated Start lets the host load a new pointer. The register-bank side is a plain strobe port. The write strobe pulses once per complete word. The read strobe pulses when the first byte of a word is due, and the bank returns data in the same cycle.

Top module: `i2c_regbank_target`

## Requirements
- R1: The device address is 0x14 + {strap_i[1],strap_i[0]}, sampled on the first clock after reset release; later changes of strap_i have no effect until the next reset.
- R2: A first byte whose upper seven bits differ from the device address gets no acknowledge (SDA stays high in the ninth bit), and the target keeps SDA released and issues no strobe until the next Start.
- R3: In a write (first byte bit 0 = 0), the target acknowledges every byte by pulling SDA low in the ninth clock. The bytes after the two pointer bytes fill a word as bits [7:0], [15:8], [23:16], [31:24], and reg_wr_o pulses for one cycle, while SCL is low, after the fourth byte's acknowledge.
- R4: A word with fewer than four bytes when a Stop arrives is discarded: no reg_wr_o pulse occurs and the bank keeps its old value.
- R5: The pointer is two bytes, low byte [7:0] first, then [15:8]; reg_addr_o always carries the pointer with bits [1:0] cleared, so an unaligned pointer accesses the word that contains it.
- R6: After each reg_wr_o or reg_rd_o pulse, reg_addr_o advances by 4 in the next cycle.
- R7: In a read (first byte bit 0 = 1), reg_rd_o pulses for one cycle, while SCL is low, at the end of the address acknowledge; reg_rdata_i is taken in that cycle and sent byte [7:0] first, each byte MSB first.
- R8: A host acknowledge (SDA low) on the fourth byte of a word fetches the next word; a host no-acknowledge ends the read, so SDA stays released and no further reg_rd_o pulse follows.
- R9: A repeated Start discards any partial write word and restarts address decoding, so the host can load a new pointer within the same bus ownership.
- R10: Under reset sda_oe, reg_wr_o and reg_rd_o are low, and reg_wr_o and reg_rd_o are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_o | output | 1 | Value driven on SDA when enabled, always low |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| strap_i | input | 2 | Address select straps, captured after reset |
| reg_addr_o | output | 16 | Word-aligned register address |
| reg_wdata_o | output | 32 | Assembled write word |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_rd_o | output | 1 | One-cycle read strobe |
| reg_rdata_i | input | 32 | Read data, valid in the cycle of reg_rd_o |

## Verification
The bench writes through an unaligned pointer that crosses a word boundary. A design that skipped the alignment or incremented by one byte would post writes at the wrong addresses. It ends a write after two data bytes and then reads the same word back, which exposes any design that commits a partial word at Stop. It also breaks a write with a repeated Start and a new pointer; keeping the stale byte position would yield a shifted word. The bench changes the straps after power-up and addresses the newly selected value, which a design that samples the straps continuously would acknowledge. Reads continue into a second word and end with a no-acknowledge; a design that ignores that no-acknowledge would issue an extra fetch or keep driving SDA.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int REG_AW = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_HACK,
    ST_WAIT
  } st_t;

  typedef enum logic [1:0] {
    K_DEV,
    K_ALO,
    K_AHI,
    K_DATA
  } kind_t;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/i2ct_cond.sv
module i2ct_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_p_q, sda_p_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p_q <= 1'b1;
      sda_p_q <= 1'b1;
    end else begin
      scl_p_q <= scl_s;
      sda_p_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s && !scl_p_q;
  assign scl_fall  = !scl_s &&  scl_p_q;
  assign bus_start =  scl_s &&  scl_p_q &&  sda_p_q && !sda_s;
  assign bus_stop  =  scl_s &&  scl_p_q && !sda_p_q &&  sda_s;
endmodule

// File: rtl/i2ct_strap.sv
module i2ct_strap #(
  parameter logic [6:0] DEV_BASE = 7'h14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  output logic [6:0] dev_addr,
  output logic       strap_done
);
  logic [1:0] strap_q;
  logic       done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= 2'b00;
      done_q  <= 1'b0;
    end else if (!done_q) begin
      strap_q <= strap_i;
      done_q  <= 1'b1;
    end
  end

  assign dev_addr   = {DEV_BASE[6:2], strap_q};
  assign strap_done = done_q;
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
  import i2ct_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_s,
  input  logic              addr_ok,
  input  logic [6:0]        dev_addr,
  output logic [REG_AW-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              sda_oe
);
  localparam int NBYTES = DATA_W / 8;
  localparam int IDXW   = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int ALIGN  = $clog2(NBYTES);
  localparam logic [IDXW-1:0]   LAST = IDXW'(NBYTES - 1);
  localparam logic [REG_AW-1:0] STEP = REG_AW'(NBYTES);

  st_t               state_q, state_d;
  kind_t             kind_q, kind_d;
  logic              rw_q, rw_d;
  logic [3:0]        bit_q, bit_d;
  logic [7:0]        rx_q, rx_d;
  logic [7:0]        tx_q, tx_d;
  logic [IDXW-1:0]   idx_q, idx_d;
  logic [REG_AW-1:0] ptr_q, ptr_d;
  logic              hack_q, hack_d;
  logic [DATA_W-1:0] wbuf_q, wbuf_d;
  logic [DATA_W-1:0] rbuf_q;
  logic              wbuf_en, rbuf_en;

  function automatic logic [7:0] pick(input logic [DATA_W-1:0] w,
                                      input logic [IDXW-1:0] i);
    return w[i*8 +: 8];
  endfunction

  assign reg_addr = {ptr_q[REG_AW-1:ALIGN], {ALIGN{1'b0}}};

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    rw_d    = rw_q;
    bit_d   = bit_q;
    rx_d    = rx_q;
    tx_d    = tx_q;
    idx_d   = idx_q;
    ptr_d   = ptr_q;
    hack_d  = hack_q;
    wbuf_d  = wbuf_q;
    wbuf_en = 1'b0;
    rbuf_en = 1'b0;
    reg_wr  = 1'b0;
    reg_rd  = 1'b0;
    if (bus_start) begin
      state_d = ST_RX;
      kind_d  = K_DEV;
      bit_d   = 4'd0;
      idx_d   = '0;
    end else if (bus_stop) begin
      state_d = ST_IDLE;
      idx_d   = '0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && bit_q != 4'd8) begin
            rx_d  = {rx_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d   = 4'd0;
            state_d = ST_ACK;
            case (kind_q)
              K_DEV: begin
                if (addr_ok && rx_q[7:1] == dev_addr) rw_d = rx_q[0];
                else                                  state_d = ST_WAIT;
              end
              K_ALO: ptr_d[7:0]  = rx_q;
              K_AHI: ptr_d[15:8] = rx_q;
              default: begin
                wbuf_d[idx_q*8 +: 8] = rx_q;
                wbuf_en = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            state_d = ST_RX;
            case (kind_q)
              K_DEV: begin
                if (rw_q) begin
                  reg_rd  = 1'b1;
                  rbuf_en = 1'b1;
                  tx_d    = reg_rdata[7:0];
                  idx_d   = '0;
                  ptr_d   = reg_addr + STEP;
                  bit_d   = 4'd0;
                  state_d = ST_TX;
                end else begin
                  kind_d = K_ALO;
                end
              end
              K_ALO: kind_d = K_AHI;
              K_AHI: begin
                kind_d = K_DATA;
                idx_d  = '0;
              end
              default: begin
                if (idx_q == LAST) begin
                  reg_wr = 1'b1;
                  ptr_d  = reg_addr + STEP;
                  idx_d  = '0;
                end else begin
                  idx_d = idx_q + IDXW'(1);
                end
              end
            endcase
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_q == 4'd7) begin
              state_d = ST_HACK;
              bit_d   = 4'd0;
            end else begin
              bit_d = bit_q + 4'd1;
              tx_d  = {tx_q[6:0], 1'b0};
            end
          end
        end
        ST_HACK: begin
          if (scl_rise) begin
            hack_d = !sda_s;
          end else if (scl_fall) begin
            if (hack_q) begin
              state_d = ST_TX;
              if (idx_q == LAST) begin
                reg_rd  = 1'b1;
                rbuf_en = 1'b1;
                tx_d    = reg_rdata[7:0];
                idx_d   = '0;
                ptr_d   = reg_addr + STEP;
              end else begin
                idx_d = idx_q + IDXW'(1);
                tx_d  = pick(rbuf_q, idx_q + IDXW'(1));
              end
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      kind_q  <= K_DEV;
      rw_q    <= 1'b0;
      bit_q   <= 4'd0;
      rx_q    <= 8'h00;
      tx_q    <= 8'h00;
      idx_q   <= '0;
      ptr_q   <= '0;
      hack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      rw_q    <= rw_d;
      bit_q   <= bit_d;
      rx_q    <= rx_d;
      tx_q    <= tx_d;
      idx_q   <= idx_d;
      ptr_q   <= ptr_d;
      hack_q  <= hack_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       wbuf_q <= '0;
    else if (wbuf_en) wbuf_q <= wbuf_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rbuf_q <= '0;
    else if (rbuf_en) rbuf_q <= reg_rdata;
  end

  assign reg_wdata = wbuf_q;
  assign sda_oe    = (state_q == ST_ACK) || (state_q == ST_TX && !tx_q[7]);
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2ct_pkg::*;
#(
  parameter int         DATA_W      = 32,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_BASE    = 7'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_o,
  output logic              sda_oe,
  input  logic [1:0]        strap_i,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_wr_o,
  output logic              reg_rd_o,
  input  logic [DATA_W-1:0] reg_rdata_i
);
  logic       rst_meta_q, rst_int_n;
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       scl_rise, scl_fall, bus_start, bus_stop;
  logic [6:0] dev_addr;
  logic       strap_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_int_n  <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_int_n  <= rst_meta_q;
    end
  end

  i2ct_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2ct_cond i_cond (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2ct_strap #(.DEV_BASE(DEV_BASE)) i_strap (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .strap_i    (strap_i),
    .dev_addr   (dev_addr),
    .strap_done (strap_done)
  );

  i2ct_ctrl #(.DATA_W(DATA_W)) i_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_s     (sda_s),
    .addr_ok   (strap_done),
    .dev_addr  (dev_addr),
    .reg_addr  (reg_addr_o),
    .reg_wdata (reg_wdata_o),
    .reg_wr    (reg_wr_o),
    .reg_rd    (reg_rd_o),
    .reg_rdata (reg_rdata_i),
    .sda_oe    (sda_oe)
  );

  assign sda_o = 1'b0;
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker #(
  parameter int DATA_W = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        scl_s,
  input logic        sda_oe,
  input logic        reg_wr,
  input logic        reg_rd,
  input logic [15:0] reg_addr,
  input logic        strap_done,
  input logic [6:0]  dev_addr
);
  localparam logic [15:0] STEP = 16'(DATA_W / 8);

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));

  p_wr_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  p_wr_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !scl_s);

  p_sda_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  p_rd_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  p_rd_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> !scl_s);

  p_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr || reg_rd) |=> (reg_addr == $past(reg_addr) + STEP));

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && $past(strap_done)) |-> $stable(dev_addr));
endmodule

bind i2c_regbank_target i2ct_checker #(.DATA_W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_s      (scl_s),
  .sda_oe     (sda_oe),
  .reg_wr     (reg_wr_o),
  .reg_rd     (reg_rd_o),
  .reg_addr   (reg_addr_o),
  .strap_done (strap_done),
  .dev_addr   (dev_addr)
);

// File: tb/test_i2c_regbank_target.sv
module test_i2c_regbank_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  typedef struct {
    logic [15:0] a;
    logic [31:0] d;
  } wr_t;

  logic        clk;
  logic        rst_n;
  logic        scl_h, sda_h;
  logic [1:0]  strap;
  logic        sda_o, sda_oe, reg_wr, reg_rd;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        sda_line;
  logic [31:0] mem [64];

  wr_t         exp_wr [$];
  logic [15:0] exp_rd [$];
  int n_chk = 0, n_fail = 0, n_wr = 0, n_rd = 0;

  assign sda_line  = sda_h & ~(sda_oe & ~sda_o);
  assign reg_rdata = mem[reg_addr[7:2]];

  i2c_regbank_target i_i2c_regbank_target (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_h),
    .sda_i       (sda_line),
    .sda_o       (sda_o),
    .sda_oe      (sda_oe),
    .strap_i     (strap),
    .reg_addr_o  (reg_addr),
    .reg_wdata_o (reg_wdata),
    .reg_wr_o    (reg_wr),
    .reg_rd_o    (reg_rd),
    .reg_rdata_i (reg_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [31:0] pat(input int i);
    return {8'(192 + i), 8'(64 + i), 8'(128 + i), 8'(i)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard monitor: compares bank strobes with queued expectations
  always @(negedge clk) begin
    wr_t e;
    logic [15:0] ea;
    if (rst_n && reg_wr) begin
      n_wr++;
      if (exp_wr.size() == 0) begin
        chk("R4 unexpected write address", {16'h0, reg_addr}, 32'hFFFFFFFF);
      end else begin
        e = exp_wr.pop_front();
        chk("R5 R6 write address", {16'h0, reg_addr}, {16'h0, e.a});
        chk("R3 write data", reg_wdata, e.d);
      end
      mem[reg_addr[7:2]] = reg_wdata;
    end
    if (rst_n && reg_rd) begin
      n_rd++;
      if (exp_rd.size() == 0) begin
        chk("R8 unexpected read address", {16'h0, reg_addr}, 32'hFFFFFFFF);
      end else begin
        ea = exp_rd.pop_front();
        chk("R7 read address", {16'h0, reg_addr}, {16'h0, ea});
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    wt(2);
    sda_h = b;
    wt(Q);
    scl_h = 1'b1;
    wt(Q);
    r = sda_line;
    scl_h = 1'b0;
  endtask

  task automatic start_c();
    wt(2);
    sda_h = 1'b1;
    wt(Q);
    scl_h = 1'b1;
    wt(Q);
    sda_h = 1'b0;
    wt(Q);
    scl_h = 1'b0;
  endtask

  task automatic stop_c();
    wt(2);
    sda_h = 1'b0;
    wt(Q);
    scl_h = 1'b1;
    wt(Q);
    sda_h = 1'b1;
    wt(Q);
  endtask

  task automatic sb(input logic [7:0] b, input logic exp_ack, input string tag);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    chk(tag, {31'h0, ~r}, {31'h0, exp_ack});
  endtask

  task automatic rb(input logic host_ack, input logic [7:0] exp, input string tag);
    logic r;
    logic [7:0] b;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, r);
      b[i] = r;
    end
    clk_bit(~host_ack, r);
    chk(tag, {24'h0, b}, {24'h0, exp});
  endtask

  task automatic rword(input logic [31:0] w, input logic last, input string tag);
    for (int k = 0; k < 4; k++) rb(!(last && k == 3), w[k*8 +: 8], tag);
  endtask

  task automatic sword(input logic [31:0] w, input string tag);
    for (int k = 0; k < 4; k++) sb(w[k*8 +: 8], 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_test();
  end

  initial begin
    int wr0, rd0;
    for (int i = 0; i < 64; i++) mem[i] = pat(i);
    sda_h = 1'b1;
    scl_h = 1'b1;
    strap = 2'b10;
    rst_n = 1'b0;
    wt(5);
    chk("R10 reset sda_oe", {31'h0, sda_oe}, 32'h0);
    chk("R10 reset strobes", {30'h0, reg_wr, reg_rd}, 32'h0);
    rst_n = 1'b1;
    wt(6);
    strap = 2'b01;  // R1: must not move the address
    wt(4);

    // R1 R3: plain write of one word to 0x0010 at device 0x16
    exp_wr.push_back('{16'h0010, 32'h11223344});
    start_c();
    sb(8'h2C, 1'b1, "R1 strapped address acked");
    sb(8'h10, 1'b1, "R3 pointer low ack");
    sb(8'h00, 1'b1, "R3 pointer high ack");
    sword(32'h11223344, "R3 data ack");
    stop_c();
    wt(10);
    chk("R3 one write committed", n_wr, 1);

    // R2 R1: address selected by late strap value is ignored
    wr0 = n_wr; rd0 = n_rd;
    start_c();
    sb(8'h2A, 1'b0, "R2 R1 foreign address not acked");
    sb(8'h10, 1'b0, "R2 following byte not acked");
    stop_c();
    wt(10);
    chk("R2 no strobes", n_wr + n_rd, wr0 + rd0);
    chk("R2 sda released", {31'h0, sda_oe}, 32'h0);

    // R5 R6: unaligned pointer, two words
    exp_wr.push_back('{16'h0020, 32'h55667788});
    exp_wr.push_back('{16'h0024, 32'h0BADF00D});
    start_c();
    sb(8'h2C, 1'b1, "R5 address ack");
    sb(8'h23, 1'b1, "R5 pointer low ack");
    sb(8'h00, 1'b1, "R5 pointer high ack");
    sword(32'h55667788, "R6 data ack");
    sword(32'h0BADF00D, "R6 data ack");
    stop_c();
    wt(10);
    chk("R6 two writes", n_wr, 3);

    // R4: partial word dropped at Stop
    wr0 = n_wr;
    start_c();
    sb(8'h2C, 1'b1, "R4 address ack");
    sb(8'h30, 1'b1, "R4 pointer low ack");
    sb(8'h00, 1'b1, "R4 pointer high ack");
    sb(8'hDE, 1'b1, "R4 data ack");
    sb(8'hAD, 1'b1, "R4 data ack");
    stop_c();
    wt(10);
    chk("R4 no write on partial word", n_wr, wr0);

    // R7 R8: read two words from 0x0010 through a repeated Start
    exp_rd.push_back(16'h0010);
    exp_rd.push_back(16'h0014);
    start_c();
    sb(8'h2C, 1'b1, "R7 address ack");
    sb(8'h10, 1'b1, "R7 pointer low ack");
    sb(8'h00, 1'b1, "R7 pointer high ack");
    start_c();
    sb(8'h2D, 1'b1, "R7 read address ack");
    rword(32'h11223344, 1'b0, "R7 read byte");
    rword(pat(5), 1'b1, "R8 next word byte");
    wt(40);
    chk("R8 sda released after nack", {31'h0, sda_oe}, 32'h0);
    stop_c();
    wt(10);
    chk("R8 two fetches only", n_rd, 2);

    // R4: bank word at 0x0030 untouched, read back at the ports
    exp_rd.push_back(16'h0030);
    start_c();
    sb(8'h2C, 1'b1, "R4 address ack");
    sb(8'h30, 1'b1, "R4 pointer low ack");
    sb(8'h00, 1'b1, "R4 pointer high ack");
    start_c();
    sb(8'h2D, 1'b1, "R4 read address ack");
    rword(pat(12), 1'b1, "R4 old word kept");
    stop_c();

    // R6: second word of the unaligned write read back at 0x0024
    exp_rd.push_back(16'h0024);
    start_c();
    sb(8'h2C, 1'b1, "R6 address ack");
    sb(8'h24, 1'b1, "R6 pointer low ack");
    sb(8'h00, 1'b1, "R6 pointer high ack");
    start_c();
    sb(8'h2D, 1'b1, "R6 read address ack");
    rword(32'h0BADF00D, 1'b1, "R6 stored word");
    stop_c();

    // R9: repeated Start mid-word, new pointer
    exp_wr.push_back('{16'h0050, 32'hD4C3B2A1});
    wr0 = n_wr;
    start_c();
    sb(8'h2C, 1'b1, "R9 address ack");
    sb(8'h40, 1'b1, "R9 pointer low ack");
    sb(8'h00, 1'b1, "R9 pointer high ack");
    sb(8'h01, 1'b1, "R9 data ack");
    sb(8'h02, 1'b1, "R9 data ack");
    start_c();
    sb(8'h2C, 1'b1, "R9 address ack again");
    sb(8'h50, 1'b1, "R9 new pointer low ack");
    sb(8'h00, 1'b1, "R9 new pointer high ack");
    sword(32'hD4C3B2A1, "R9 data ack");
    stop_c();
    wt(10);
    chk("R9 single write", n_wr, wr0 + 1);

    // R1: new power-up with straps 00 selects 0x14
    rst_n = 1'b0;
    strap = 2'b00;
    wt(5);
    rst_n = 1'b1;
    wt(10);
    start_c();
    sb(8'h28, 1'b1, "R1 address 0x14 acked");
    stop_c();
    start_c();
    sb(8'h2C, 1'b0, "R1 address 0x16 now ignored");
    stop_c();
    wt(10);

    chk("R3 write queue drained", exp_wr.size(), 0);
    chk("R7 read queue drained", exp_rd.size(), 0);
    finish_test();
  end
endmodule